// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer

This block is a 16-bit up-counter paired with a 16-bit capture/reload holding register and an 8-bit control register. It can count in two ways. As a timer, it advances once per machine cycle, which is a fixed number of oscillator clocks. As an event counter, it advances on each falling edge of an external count pin. A second external pin, the trigger, can do one of two things on its falling edge: copy the live count into the holding register, or load the count from that register.

When the count rolls over, the block either wraps to zero and raises an overflow flag (capture mode), or loads the holding register and raises the flag (reload mode). A baud-clock mode forces reload on every rollover, never sets the overflow flag, and sends out a one-clock pulse for each rollover. This pulse can serve as the bit clock of a serial port. Software reaches every register through a plain byte-wide read/write bus. The two flags stay set until software clears them, and an enable input gates them onto a single interrupt line.

Top module: `crt_timer`

## Requirements
- R1: In timer mode (control bit 1 = 0) with run (bit 2) set, the count rises by exactly one every TICK_DIV clock periods.
- R2: In counter mode (bit 1 = 1) with run set, the count rises by one for each falling edge of `cnt_pin` and ignores machine cycles. Each pin level must be held for at least two machine cycles. Edges are found by sampling the synchronised pin once per machine cycle.
- R3: While run is 0, the count holds its value unless the bus writes it or a trigger reload occurs.
- R4: In capture mode (bit 0 = 1, bit 4 = 0), the step from all-ones wraps the count to zero and sets the overflow flag (bit 7).
- R5: In reload mode (bit 0 = 0), the step from all-ones loads the count from the holding register and sets the overflow flag.
- R6: With external enable (bit 3) set in capture mode, a falling edge on `trig_pin` copies the count into the holding register and sets the external flag (bit 6).
- R7: With external enable set in reload mode, a falling edge on `trig_pin` loads the count from the holding register and sets the external flag.
- R8: With external enable clear, `trig_pin` edges change neither the count, nor the holding register, nor the external flag.
- R9: With baud mode (bit 4) set, every rollover reloads the count whatever bit 0 holds. The overflow flag is not set. `baud_pulse` goes high for one clock per rollover.
- R10: The flags in bits 7 and 6 are set only by hardware and stay set. A control write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged. A hardware set in the same cycle takes priority.
- R11: `irq` is high exactly when `irq_en` is high and at least one of the two flags is set.
- R12: Reset clears all registers to zero. Bus address 0 is control, 1/2 are count low/high, 3/4 are holding low/high, and any other address reads zero. A bus write to a data register takes priority over hardware updates in the same cycle.
- R13: The general-purpose bit 5 reads back whatever software last wrote to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the byte bus |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cnt_pin | input | 1 | External count input (asynchronous) |
| trig_pin | input | 1 | External capture/reload trigger (asynchronous) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| baud_pulse | output | 1 | One-clock pulse per rollover in baud mode |

## Verification
The bench builds the block with TICK_DIV set to 4 and the default 16-bit count and two synchroniser stages. A short machine cycle lets the bench run multi-rollover reload and baud sequences, and edge-by-edge event counting, in a few hundred clocks. It also makes timer runs exact: a run window of 4k clocks always gives exactly k increments, whatever the tick phase. The full 16-bit width is kept, so the all-ones rollover is reached by preloading counts near 0xFFFF.

// File: rtl/crt_pkg.sv
// Shared types for the capture/reload timer.
// Assumes an 8-bit control register whose bit order software decodes.
package crt_pkg;
    // Control register, bit 7 down to bit 0.
    typedef struct packed {
        logic ovf;     // 7: overflow flag
        logic ext;     // 6: external-event flag
        logic gp;      // 5: general purpose
        logic baud;    // 4: baud-clock mode
        logic ext_en;  // 3: external trigger enable
        logic run;     // 2: run
        logic ctsel;   // 1: 0 timer, 1 event counter
        logic capsel;  // 0: 1 capture, 0 reload
    } crt_ctrl_t;

    localparam int unsigned CTRL_W = $bits(crt_ctrl_t);
endpackage

// File: rtl/crt_tick.sv
// Machine-cycle tick generator.
// Emits a one-clock tick once every TICK_DIV clocks; assumes TICK_DIV >= 1.
module crt_tick #(
    parameter int unsigned TICK_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pcnt_q;

    assign tick = (pcnt_q == LAST);

    // Divide the clock down to the machine-cycle rate.
    always_ff @(posedge clk) begin
        if (!rst_n)     pcnt_q <= '0;
        else if (tick)  pcnt_q <= '0;
        else            pcnt_q <= pcnt_q + 1'b1;
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // Ticks never come back to back when the divider exceeds one.
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/crt_edge.sv
// Falling-edge detector for an asynchronous pin.
// The pin passes through SYNC_STAGES flops, then it is sampled once per
// machine tick. A fall is reported on the tick where the sample first reads
// low after a high sample. Assumes SYNC_STAGES >= 2.
module crt_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];
    assign fall   = tick & samp_q & ~synced;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Keep the level seen at the previous machine tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    samp_q <= 1'b0;
        else if (tick) samp_q <= synced;
    end

    // A detected edge is always aligned to a machine tick.
    assert_fall_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> tick);
endmodule

// File: rtl/crt_core.sv
// Counter, holding register and control register of the timer.
// Assumes CNT_W is a whole number of BUS_W bytes. Bus writes to data bytes
// win over hardware updates; hardware flag sets win over software clears.
module crt_core
    import crt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned BUS_W = 8,
    localparam int unsigned NB   = CNT_W / BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_fall,
    input  logic             trig_fall,
    input  logic             ctrl_wr,
    input  logic [NB-1:0]    cnt_be,
    input  logic [NB-1:0]    rld_be,
    input  logic [BUS_W-1:0] wdata,
    output crt_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rld_q,
    output logic             baud_pulse
);
    crt_ctrl_t        ctrl_d;
    logic [CNT_W-1:0] cnt_d, rld_d, cnt_hw;
    logic inc, at_top, ovf_evt, reload_mode, trig_act, trig_load, trig_cap;

    // Event decode: step source, rollover and trigger action.
    always_comb begin
        inc         = ctrl_q.run & (ctrl_q.ctsel ? cnt_fall : tick);
        at_top      = &cnt_q;
        ovf_evt     = inc & at_top;
        reload_mode = ctrl_q.baud | ~ctrl_q.capsel;
        trig_act    = ctrl_q.ext_en & trig_fall;
        trig_load   = trig_act & reload_mode;
        trig_cap    = trig_act & ~reload_mode;
    end

    // Hardware next count: reload, step or hold.
    always_comb begin
        cnt_hw = cnt_q;
        if (trig_load || (ovf_evt && reload_mode)) cnt_hw = rld_q;
        else if (inc)                              cnt_hw = cnt_q + 1'b1;
    end

    // Merge byte writes over the hardware values.
    always_comb begin
        cnt_d = cnt_hw;
        rld_d = trig_cap ? cnt_q : rld_q;
        for (int b = 0; b < NB; b++) begin
            if (cnt_be[b]) cnt_d[b*BUS_W +: BUS_W] = wdata;
            if (rld_be[b]) rld_d[b*BUS_W +: BUS_W] = wdata;
        end
    end

    // Control next state: software fields, clear-only flags, hardware sets.
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d        = crt_ctrl_t'(wdata[CTRL_W-1:0]);
            ctrl_d.ovf    = ctrl_q.ovf & wdata[7];
            ctrl_d.ext    = ctrl_q.ext & wdata[6];
        end
        if (ovf_evt && !ctrl_q.baud) ctrl_d.ovf = 1'b1;
        if (trig_act)                ctrl_d.ext = 1'b1;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            cnt_q      <= '0;
            rld_q      <= '0;
            baud_pulse <= 1'b0;
        end else begin
            ctrl_q     <= ctrl_d;
            cnt_q      <= cnt_d;
            rld_q      <= rld_d;
            baud_pulse <= ovf_evt & ctrl_q.baud;
        end
    end

    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !trig_load && !(|cnt_be)) |=> $stable(cnt_q));
    assert_reload_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && reload_mode && !(|cnt_be)) |=> (cnt_q == $past(rld_q)));
    assert_capture_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cap && !(|rld_be)) |=> (rld_q == $past(cnt_q)));
    assert_no_flag_in_baud_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.baud && !ctrl_q.ovf) |=> !ctrl_q.ovf);
    assert_pulse_only_in_baud_R9: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse |-> $past(ctrl_q.baud));
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ovf && !ctrl_wr) |=> ctrl_q.ovf);
endmodule

// File: rtl/crt_timer.sv
// Top of the capture/reload timer: byte bus decode, read mux, interrupt.
// Assumes CNT_W is a multiple of 8. Read data is combinational from address.
module crt_timer
    import crt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned TICK_DIV    = 12,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = $clog2(2 * (CNT_W / 8) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              irq_en,
    output logic              irq,
    output logic              baud_pulse
);
    localparam int unsigned NB = CNT_W / 8;

    logic             tick, cnt_fall, trig_fall, ctrl_wr;
    logic [NB-1:0]    cnt_be, rld_be;
    crt_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cnt_q, rld_q;

    crt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    crt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin), .fall(cnt_fall));

    crt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig_edge (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(trig_pin), .fall(trig_fall));

    // Decode write strobes per register byte.
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));
        for (int b = 0; b < NB; b++) begin
            cnt_be[b] = bus_wr && (bus_addr == ADDR_W'(1 + b));
            rld_be[b] = bus_wr && (bus_addr == ADDR_W'(1 + NB + b));
        end
    end

    crt_core #(.CNT_W(CNT_W), .BUS_W(8)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_fall(cnt_fall),
        .trig_fall(trig_fall), .ctrl_wr(ctrl_wr), .cnt_be(cnt_be),
        .rld_be(rld_be), .wdata(bus_wdata), .ctrl_q(ctrl_q), .cnt_q(cnt_q),
        .rld_q(rld_q), .baud_pulse(baud_pulse));

    // Select the addressed byte; unused addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(0)) bus_rdata = ctrl_q;
        for (int b = 0; b < NB; b++) begin
            if (bus_addr == ADDR_W'(1 + b))      bus_rdata = cnt_q[b*8 +: 8];
            if (bus_addr == ADDR_W'(1 + NB + b)) bus_rdata = rld_q[b*8 +: 8];
        end
    end

    // Interrupt request from either flag.
    assign irq = irq_en & (ctrl_q.ovf | ctrl_q.ext);

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && (ctrl_q.ovf || ctrl_q.ext)));
endmodule

// File: tb/crt_timer_bench.sv
module crt_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TK         = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq, baud_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    logic [15:0] v16;
    logic [7:0]  v8;

    crt_timer #(.CNT_W(16), .TICK_DIV(TK), .SYNC_STAGES(2)) u_crt_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .irq_en(irq_en), .irq(irq), .baud_pulse(baud_pulse));

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (baud_pulse) pulses <= pulses + 1;

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] rld;
        logic [7:0]  ctrl;
        logic [7:0]  ticks;
        logic [15:0] exp_cnt;
        logic [7:0]  exp_ctrl;
        logic [7:0]  exp_pulses;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0010, 16'h0000, 8'h05, 8'd5,  16'h0015, 8'h01, 8'd0}, // R1
        '{16'hFFFE, 16'h0000, 8'h05, 8'd3,  16'h0001, 8'h81, 8'd0}, // R4
        '{16'hFFFF, 16'h1234, 8'h04, 8'd2,  16'h1235, 8'h80, 8'd0}, // R5
        '{16'hFFFE, 16'hFFFE, 8'h15, 8'd8,  16'hFFFE, 8'h11, 8'd4}, // R9
        '{16'h4242, 16'h0000, 8'h01, 8'd6,  16'h4242, 8'h01, 8'd0}, // R3
        '{16'hFFFF, 16'hFFF0, 8'h04, 8'd17, 16'hFFF0, 8'h80, 8'd0}  // R5
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
    endtask

    task automatic load(input logic [15:0] c, input logic [15:0] r);
        wr(3'd0, 8'h00);
        wr(3'd1, c[7:0]); wr(3'd2, c[15:8]);
        wr(3'd3, r[7:0]); wr(3'd4, r[15:8]);
    endtask

    task automatic trig_fall_seq();
        trig_pin = 1'b0;
        repeat (6 * TK) @(negedge clk);
        trig_pin = 1'b1;
        repeat (6 * TK) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        irq_en = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        rd(3'd0, v8);  check("R12 ctrl after reset", 16'(v8), 16'h00);
        rd16(3'd1, v16); check("R12 count after reset", v16, 16'h0000);
        rd16(3'd3, v16); check("R12 hold after reset", v16, 16'h0000);
        check("R12 irq after reset", 16'(irq), 16'h0);
        check("R12 baud_pulse after reset", 16'(baud_pulse), 16'h0);
        irq_en = 1'b0;

        // Vector table: timer-mode runs of exactly ticks*TK clocks.
        foreach (VECS[i]) begin
            load(VECS[i].start, VECS[i].rld);
            pulses = 0;
            wr(3'd0, VECS[i].ctrl);
            repeat (int'(VECS[i].ticks) * TK - 1) @(negedge clk);
            wr(3'd0, (VECS[i].ctrl & 8'hFB) | 8'hC0);
            repeat (2) @(negedge clk);
            rd16(3'd1, v16); check($sformatf("R1/R3/R4/R5/R9 vec%0d count", i), v16, VECS[i].exp_cnt);
            rd(3'd0, v8);    check($sformatf("R4/R5/R9/R10 vec%0d ctrl", i), 16'(v8), 16'(VECS[i].exp_ctrl));
            check($sformatf("R9 vec%0d pulses", i), 16'(pulses), 16'(VECS[i].exp_pulses));
        end

        // R2: five events in counter mode; machine ticks alone do not count.
        load(16'h0000, 16'h0000);
        wr(3'd0, 8'h06);
        for (int k = 0; k < 5; k++) begin
            cnt_pin = 1'b0; repeat (3 * TK) @(negedge clk);
            cnt_pin = 1'b1; repeat (3 * TK) @(negedge clk);
        end
        wr(3'd0, 8'hC2);
        rd16(3'd1, v16); check("R2 event count", v16, 16'd5);

        // R8: trigger ignored with external enable clear.
        load(16'h2222, 16'h1111);
        wr(3'd0, 8'h01);
        trig_fall_seq();
        rd16(3'd3, v16); check("R8 hold unchanged", v16, 16'h1111);
        rd16(3'd1, v16); check("R8 count unchanged", v16, 16'h2222);
        rd(3'd0, v8);    check("R8 no ext flag", 16'(v8), 16'h01);

        // R6: trigger capture.
        load(16'hABCD, 16'h0000);
        wr(3'd0, 8'h09);
        trig_fall_seq();
        rd16(3'd3, v16); check("R6 captured value", v16, 16'hABCD);
        rd(3'd0, v8);    check("R6 ext flag set", 16'(v8), 16'h49);

        // R11 and R10: irq gating and sticky flag.
        irq_en = 1'b1; #1;
        check("R11 irq with enable", 16'(irq), 16'h1);
        irq_en = 1'b0; #1;
        check("R11 irq gated off", 16'(irq), 16'h0);
        irq_en = 1'b1;
        repeat (20) @(negedge clk);
        wr(3'd0, 8'hC9);
        rd(3'd0, v8);    check("R10 flag kept by write of 1", 16'(v8), 16'h49);
        wr(3'd0, 8'h09);
        rd(3'd0, v8);    check("R10 flag cleared by write of 0", 16'(v8), 16'h09);
        check("R11 irq after clear", 16'(irq), 16'h0);
        irq_en = 1'b0;

        // R7: trigger reload.
        load(16'h7777, 16'h0055);
        wr(3'd0, 8'h08);
        trig_fall_seq();
        rd16(3'd1, v16); check("R7 reloaded count", v16, 16'h0055);
        rd(3'd0, v8);    check("R7 ext flag set", 16'(v8), 16'h48);

        // R13: general-purpose bit.
        wr(3'd0, 8'h20);
        rd(3'd0, v8);    check("R13 gp readback", 16'(v8), 16'h20);
        rd(3'd6, v8);    check("R12 unused address", 16'(v8), 16'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule